// File: doc/BRIEF.md
# Secure FP Context Register Unit

This block holds the state behind a composite system register that saves and restores the secure floating-point context. It keeps three pieces of state: a 32-bit FP status/control word, a one-bit "secure FP active" flag, and a Non-secure default status word. A read of the composite register returns the low 28 bits of the status word with the active flag in the top bit. A write puts the value back into the status word and the flag, and leaves the condition-flag nibble of the status word as it was.

A read also has a side effect. Once its data has been delivered, the active flag is cleared and the whole status word is reloaded from the Non-secure default. The read value is captured first. The side effect waits for a completion acknowledge from whatever consumes the data, and it is dropped if that delivery reports a fault. While a read is waiting for its acknowledge, the unit accepts no further access. Access is allowed only when the feature-enable input is set and the processor is in Secure state. Any other access is refused with a fault pulse.

Top module: `fp_secctx_unit`

## Requirements
- R1: After a synchronous reset, the status word, the active flag, the default word, the read data, the fault output and the pending output are all zero.
- R2: An access with `feat_en` low or `sec_state` low, and no read pending, pulses `acc_fault` high for the next cycle. It changes neither the status word nor the active flag, and it starts no pending read.
- R3: The read value has bits [27:0] equal to status-word bits [27:0], bits [30:28] equal to zero, and bit 31 equal to the active flag.
- R4: A permitted write sets the active flag to write-data bit 31 and status bits [27:0] to write-data bits [27:0]. Status bits [31:28] (N, Z, C, V) keep their values. The result is visible in the cycle after the strobe.
- R5: A permitted read puts the value held before any side effect on `acc_rdata` and raises `rd_pending` in the cycle after the strobe. The status word and the flag are not changed at that point.
- R6: In the cycle when `dlv_ack` is high with `dlv_fault` low while a read is pending, the active flag clears and the whole status word takes the default word. `rd_pending` falls at the same edge.
- R7: When `dlv_ack` is high with `dlv_fault` high while a read is pending, `rd_pending` falls and the status word and the flag stay unchanged.
- R8: While `rd_pending` is high, any access strobe is ignored. No state changes, `acc_fault` stays low and `acc_rdata` holds its value.
- R9: The default word loads from `dflt_wdata` when `dflt_we` is high. If that load falls on a commit cycle, the status word takes the default value from before the load.
- R10: An acknowledge with no read pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Extended-architecture feature present |
| sec_state | input | 1 | Processor is in Secure state |
| acc_req | input | 1 | Access strobe, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Captured read value |
| acc_fault | output | 1 | Access refused (one-cycle pulse) |
| rd_pending | output | 1 | Read waiting for delivery acknowledge |
| dlv_ack | input | 1 | Read data delivery complete |
| dlv_fault | input | 1 | Delivery faulted (qualifies dlv_ack) |
| dflt_we | input | 1 | Load the Non-secure default word |
| dflt_wdata | input | 32 | Default word value |
| stat_out | output | 32 | Current FP status/control word |
| act_out | output | 1 | Current secure-FP-active flag |

## Verification
Two functions can fall in the same cycle: the commit of a read's side effect and a load of the Non-secure default word. The bench provokes this by raising `dlv_ack` and `dflt_we` together while a read is pending. It passes only if the status word takes the old default and the new default appears only at the next committed read. A second overlap is also driven: an access strobe arriving while a read waits for its acknowledge. It is judged by the status word, the flag, the fault output and the held read data all staying unchanged.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned FLAG_LSB = 28;   // condition flags occupy [31:28]
    localparam int unsigned ACT_POS  = 31;   // active flag position in the composite value

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  act;
        word_t stat;
    } ctx_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_REJECT = 2'd3
    } op_e;

    function automatic word_t pack_ctx(input ctx_t c);
        word_t r;
        r = '0;
        r[FLAG_LSB-1:0] = c.stat[FLAG_LSB-1:0];
        r[ACT_POS]      = c.act;
        return r;
    endfunction

    function automatic ctx_t merge_write(input ctx_t c, input word_t w);
        ctx_t n;
        n = c;
        n.act = w[ACT_POS];
        n.stat[FLAG_LSB-1:0] = w[FLAG_LSB-1:0];
        return n;
    endfunction
endpackage

// File: rtl/fpctx_gate.sv
module fpctx_gate
    import fpctx_pkg::*;
(
    input  logic acc_req,
    input  logic acc_wr,
    input  logic feat_en,
    input  logic sec_state,
    input  logic busy,
    output op_e  op
);
    logic permit;
    assign permit = feat_en & sec_state;

    always_comb begin
        op = OP_NONE;
        if (acc_req && !busy) begin
            if (!permit)     op = OP_REJECT;
            else if (acc_wr) op = OP_WRITE;
            else             op = OP_READ;
        end
    end
endmodule

// File: rtl/fpctx_state.sv
module fpctx_state
    import fpctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  word_t wdata,
    input  logic  commit,
    input  logic  dflt_we,
    input  word_t dflt_wdata,
    output ctx_t  ctx,
    output word_t dflt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx  <= '0;
            dflt <= '0;
        end else begin
            if (op == OP_WRITE)
                ctx <= merge_write(ctx, wdata);
            else if (commit) begin
                ctx.act  <= 1'b0;
                ctx.stat <= dflt;
            end
            if (dflt_we)
                dflt <= dflt_wdata;
        end
    end

    assert_write_keeps_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> ctx.stat[WORD_W-1:FLAG_LSB] == $past(ctx.stat[WORD_W-1:FLAG_LSB]));

    assert_write_sets_act_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> ctx.act == $past(wdata[ACT_POS]));

    assert_commit_reload_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (!ctx.act && ctx.stat == $past(dflt)));
endmodule

// File: rtl/fpctx_rdpath.sv
module fpctx_rdpath
    import fpctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  ctx_t  ctx,
    input  logic  acc_req,
    input  logic  dlv_ack,
    input  logic  dlv_fault,
    output word_t rdata,
    output logic  fault,
    output logic  pending,
    output logic  commit
);
    assign commit = pending & dlv_ack & ~dlv_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            fault   <= 1'b0;
            pending <= 1'b0;
        end else begin
            fault <= (op == OP_REJECT);
            if (op == OP_READ) begin
                rdata   <= pack_ctx(ctx);
                pending <= 1'b1;
            end else if (pending && dlv_ack) begin
                pending <= 1'b0;
            end
        end
    end

    assert_busy_holds_rdata_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && acc_req && !dlv_ack) |=> ($stable(rdata) && pending && !fault));

    assert_read_mid_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> rdata[ACT_POS-1:FLAG_LSB] == '0);
endmodule

// File: rtl/fp_secctx_unit.sv
module fp_secctx_unit
    import fpctx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        feat_en,
    input  logic        sec_state,
    input  logic        acc_req,
    input  logic        acc_wr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_fault,
    output logic        rd_pending,
    input  logic        dlv_ack,
    input  logic        dlv_fault,
    input  logic        dflt_we,
    input  logic [31:0] dflt_wdata,
    output logic [31:0] stat_out,
    output logic        act_out
);
    op_e   op;
    ctx_t  ctx;
    word_t dflt;
    logic  commit;

    fpctx_gate u_gate (
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .feat_en   (feat_en),
        .sec_state (sec_state),
        .busy      (rd_pending),
        .op        (op)
    );

    fpctx_state u_state (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .wdata      (acc_wdata),
        .commit     (commit),
        .dflt_we    (dflt_we),
        .dflt_wdata (dflt_wdata),
        .ctx        (ctx),
        .dflt       (dflt)
    );

    fpctx_rdpath u_rd (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ctx       (ctx),
        .acc_req   (acc_req),
        .dlv_ack   (dlv_ack),
        .dlv_fault (dlv_fault),
        .rdata     (acc_rdata),
        .fault     (acc_fault),
        .pending   (rd_pending),
        .commit    (commit)
    );

    assign stat_out = ctx.stat;
    assign act_out  = ctx.act;

    assert_reject_no_change_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !rd_pending && !(feat_en && sec_state))
            |=> ($stable(stat_out) && $stable(act_out) && acc_fault && !rd_pending));

    assert_dlv_fault_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_pending && dlv_ack && dlv_fault)
            |=> ($stable(stat_out) && $stable(act_out) && !rd_pending));

    assert_idle_ack_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_pending && !acc_req && dlv_ack) |=> ($stable(stat_out) && $stable(act_out)));
endmodule

// File: tb/sim_fp_secctx_unit.sv
module sim_fp_secctx_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        feat_en = 1'b0, sec_state = 1'b0;
    logic        acc_req = 1'b0, acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_fault, rd_pending;
    logic        dlv_ack = 1'b0, dlv_fault = 1'b0;
    logic        dflt_we = 1'b0;
    logic [31:0] dflt_wdata = '0;
    logic [31:0] stat_out;
    logic        act_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fp_secctx_unit u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, release, sample at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0; dlv_ack = 1'b0; dlv_fault = 1'b0; dflt_we = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [31:0] d);
        acc_req = 1'b1; acc_wr = wr; acc_wdata = d;
        step();
    endtask

    task automatic ack(input logic f);
        dlv_ack = 1'b1; dlv_fault = f;
        step();
    endtask

    task automatic load_dflt(input logic [31:0] d);
        dflt_we = 1'b1; dflt_wdata = d;
        step();
    endtask

    task automatic t_reset();
        chk("R1 stat", stat_out, 32'h0);
        chk("R1 act", {31'h0, act_out}, 32'h0);
        chk("R1 rdata", acc_rdata, 32'h0);
        chk("R1 fault", {31'h0, acc_fault}, 32'h0);
        chk("R1 pending", {31'h0, rd_pending}, 32'h0);
        feat_en = 1'b1; sec_state = 1'b1;
        access(1'b0, 32'h0);
        chk("R1 default zero read", acc_rdata, 32'h0);
        ack(1'b0);
        chk("R1 default zero reload", stat_out, 32'h0);
    endtask

    task automatic t_reject();
        feat_en = 1'b0; sec_state = 1'b1;
        access(1'b1, 32'h8FFF_FFFF);
        chk("R2 fault no feature", {31'h0, acc_fault}, 32'h1);
        chk("R2 stat kept", stat_out, 32'h0);
        chk("R2 act kept", {31'h0, act_out}, 32'h0);
        feat_en = 1'b1; sec_state = 1'b0;
        access(1'b0, 32'h0);
        chk("R2 fault nonsecure", {31'h0, acc_fault}, 32'h1);
        chk("R2 no pending", {31'h0, rd_pending}, 32'h0);
        sec_state = 1'b1;
        @(negedge clk);
        chk("R2 fault is a pulse", {31'h0, acc_fault}, 32'h0);
    endtask

    task automatic t_write_read();
        access(1'b1, 32'hF123_4567);
        chk("R4 stat low bits", stat_out, 32'h0123_4567);
        chk("R4 act set", {31'h0, act_out}, 32'h1);
        chk("R4 no fault", {31'h0, acc_fault}, 32'h0);
        access(1'b1, 32'h7AAA_AAAA);
        chk("R4 act cleared", {31'h0, act_out}, 32'h0);
        access(1'b0, 32'h0);
        chk("R3 read compose", acc_rdata, 32'h0AAA_AAAA);
        chk("R5 pending", {31'h0, rd_pending}, 32'h1);
        chk("R5 stat unchanged", stat_out, 32'h0AAA_AAAA);
        access(1'b1, 32'hFFFF_FFFF);
        chk("R8 stat unchanged", stat_out, 32'h0AAA_AAAA);
        chk("R8 rdata held", acc_rdata, 32'h0AAA_AAAA);
        chk("R8 no fault", {31'h0, acc_fault}, 32'h0);
        chk("R8 still pending", {31'h0, rd_pending}, 32'h1);
        ack(1'b1);
        chk("R7 pending cleared", {31'h0, rd_pending}, 32'h0);
        chk("R7 stat kept", stat_out, 32'h0AAA_AAAA);
    endtask

    task automatic t_commit();
        load_dflt(32'hC000_1234);
        access(1'b1, 32'h8000_0055);
        access(1'b0, 32'h0);
        chk("R3 read with act", acc_rdata, 32'h8000_0055);
        chk("R5 act before ack", {31'h0, act_out}, 32'h1);
        ack(1'b1);
        chk("R7 act kept", {31'h0, act_out}, 32'h1);
        access(1'b0, 32'h0);
        ack(1'b0);
        chk("R6 stat reloaded", stat_out, 32'hC000_1234);
        chk("R6 act cleared", {31'h0, act_out}, 32'h0);
        chk("R6 pending cleared", {31'h0, rd_pending}, 32'h0);
        access(1'b1, 32'h0000_0077);
        chk("R4 flags kept", stat_out, 32'hC000_0077);
        access(1'b0, 32'h0);
        chk("R3 flags masked", acc_rdata, 32'h0000_0077);
        ack(1'b0);
    endtask

    task automatic t_same_cycle();
        access(1'b1, 32'h0000_0001);
        access(1'b0, 32'h0);
        dflt_we = 1'b1; dflt_wdata = 32'h5000_0009;
        ack(1'b0);
        chk("R9 old default used", stat_out, 32'hC000_1234);
        access(1'b0, 32'h0);
        ack(1'b0);
        chk("R9 new default used", stat_out, 32'h5000_0009);
        access(1'b1, 32'h8000_0003);
        ack(1'b0);
        chk("R10 idle ack stat", stat_out, 32'h5000_0003);
        chk("R10 idle ack act", {31'h0, act_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reject();
        t_write_read();
        t_commit();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule